// File: doc/BRIEF.md
# 16-Bit Input-Capture Timer with Byte-Wide Atomic Read

The block runs a 16-bit counter that advances once per clock. An external capture pin is brought into the clock domain and watched for one chosen edge. When that edge arrives, the count of that moment is frozen in a 16-bit read-only capture register and a capture flag is raised. Software clears the flag by writing a one to it.

A processor with an 8-bit data path reaches the block through a small byte address bus with separate read and write strobes. A 16-bit value cannot cross that bus in one access, so a single shared byte latch holds the upper half. Reading a low byte returns that byte and parks the matching high byte in the latch. Reading the high byte afterwards returns the latch, so both halves come from the same instant. Counter writes use the same latch in the other direction. Because capture reads and counter accesses share one latch, software must not let one 16-bit access fall between the two byte accesses of another.

The bus has no handshake and no back-pressure. A strobe is accepted in the cycle it is high. Read data comes from a register and is valid in the cycle after the read strobe. No stream interface is present, so every pin is a plain control or data pin.

Top module: `icap_timer16`

## Requirements
- R1: After reset the capture register, capture flag, edge-select bit, counter and read-data output are all zero. The capture register changes only on a capture.
- R2: The counter adds one on every clock that has no counter load, and it wraps from 0xFFFF to 0x0000.
- R3: If the capture pin takes a new level before clock edge k and that change is the selected edge, then at edge k+2 the capture register loads the counter value held after edge k+1 and the flag becomes 1.
- R4: Bit 0 of the control register at address 0 selects the edge: 1 selects rising and 0 selects falling. The opposite edge changes neither the capture register nor the flag.
- R5: A read of address 2 returns capture bits [7:0] and, at the same edge, loads the shared latch with capture bits [15:8].
- R6: A read of address 3 returns the shared latch and not the live upper capture byte, so a capture between the low and high reads leaves the returned pair unchanged.
- R7: The flag is bit 0 at address 1. Writing 1 there clears it, and writing 0 has no effect. When a capture and a clear fall on the same edge, the flag ends at 1.
- R8: A read of address 4 returns counter bits [7:0] and loads the shared latch with counter bits [15:8]. A read of address 5 returns the latch. A write to address 5 stores the byte in the latch. A write to address 4 loads the counter with {latch, byte}. Any of these between the two halves of a capture read changes the high byte that the capture read returns.
- R9: Read data is registered. It is valid in the cycle after the read strobe and holds while no read is made. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_pin | input | 1 | External capture pin, asynchronous |
| bus_addr | input | 3 | Byte register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read strobe |

## Verification
The bench places a pin edge exactly one cycle after a counter load, so the expected capture value is known. If the design had the wrong synchroniser depth or sampled the count too early or too late, it would return an offset value. Edges of the wrong polarity are applied and the flag and register must stay still. A design that ignored the select bit would capture on them. The bench lands a capture between the low and high reads, which a design that returns the live high byte would get wrong. It also lands a flag clear on the same edge as a capture, where a design that gives the clear priority would lose the event. Finally it interleaves a counter read inside a capture read to show that the latch is shared, and it checks wrap-around and the byte order of counter writes.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL   = 3'd0;
  localparam addr_t A_FLAG   = 3'd1;
  localparam addr_t A_CAP_LO = 3'd2;
  localparam addr_t A_CAP_HI = 3'd3;
  localparam addr_t A_CNT_LO = 3'd4;
  localparam addr_t A_CNT_HI = 3'd5;
endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
    end
  endgenerate

  assign lvl = chain_q[TOP];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;

  assign hit = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);

  // R4: a hit only ever follows a change of the synchronised level
  p_hit_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lvl != prev_q));
endmodule

// File: rtl/icap_counter.sv
module icap_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else           count <= count + 1'b1;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> count == W'($past(count) + 1'b1));

  p_count_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
endmodule

// File: rtl/icap_capture.sv
module icap_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic [W-1:0] count,
  input  logic         clr,
  output logic [W-1:0] cap_q,
  output logic         flag_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   cap_q <= '0;
    else if (evt) cap_q <= count;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    flag_q <= 1'b0;
    else if (evt)  flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);

  p_cap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cap_q));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag_q);
endmodule

// File: rtl/icap_bus.sv
module icap_bus
  import icap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  addr_t            addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0] cap,
  input  logic [CNT_W-1:0] count,
  input  logic             flag,
  output logic [BYTE_W-1:0] rdata,
  output logic             rise_sel,
  output logic             flag_clr,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val
);
  logic [BYTE_W-1:0] temp_q;
  logic [BYTE_W-1:0] rd_mux;
  logic              ctrl_q;

  assign flag_clr = wr && (addr == A_FLAG) && wdata[0];
  assign cnt_load = wr && (addr == A_CNT_LO);
  assign cnt_val  = {temp_q, wdata};
  assign rise_sel = ctrl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        ctrl_q <= 1'b0;
    else if (wr && addr == A_CTRL)     ctrl_q <= wdata[0];

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:   rd_mux = {{(BYTE_W-1){1'b0}}, ctrl_q};
      A_FLAG:   rd_mux = {{(BYTE_W-1){1'b0}}, flag};
      A_CAP_LO: rd_mux = cap[BYTE_W-1:0];
      A_CAP_HI: rd_mux = temp_q;
      A_CNT_LO: rd_mux = count[BYTE_W-1:0];
      A_CNT_HI: rd_mux = temp_q;
      default:  rd_mux = '0;
    endcase
  end

  // shared upper-byte latch: low-byte reads fill it, counter high writes fill it
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          temp_q <= '0;
    else if (rd && addr == A_CAP_LO)     temp_q <= cap[CNT_W-1:BYTE_W];
    else if (rd && addr == A_CNT_LO)     temp_q <= count[CNT_W-1:BYTE_W];
    else if (wr && addr == A_CNT_HI)     temp_q <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;

  p_hi_from_temp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_CAP_HI) |=> rdata == $past(temp_q));

  p_lo_fills_temp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_CAP_LO) |=> temp_q == $past(cap[CNT_W-1:BYTE_W]));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/icap_timer16.sv
module icap_timer16 #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_pin,
  input  logic [icap_pkg::ADDR_W-1:0]   bus_addr,
  input  logic                          bus_rd,
  input  logic                          bus_wr,
  input  logic [icap_pkg::BYTE_W-1:0]   bus_wdata,
  output logic [icap_pkg::BYTE_W-1:0]   bus_rdata
);
  import icap_pkg::*;

  logic             rise_sel;
  logic             hit;
  logic             flag_clr;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  icap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise_sel(rise_sel), .hit(hit)
  );

  icap_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .count(count)
  );

  icap_capture #(.W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt(hit), .count(count), .clr(flag_clr),
    .cap_q(cap_q), .flag_q(flag_q)
  );

  icap_bus u_bus (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .cap(cap_q), .count(count), .flag(flag_q),
    .rdata(bus_rdata), .rise_sel(rise_sel), .flag_clr(flag_clr),
    .cnt_load(cnt_load), .cnt_val(cnt_val)
  );
endmodule

// File: tb/tb_icap_timer16.sv
module tb_icap_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_pin = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] got;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  icap_timer16 dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and leave at a falling edge
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    bus_read(3'd0, got); check("R1 ctrl", got, 8'h00);
    bus_read(3'd1, got); check("R1 flag", got, 8'h00);
    bus_read(3'd2, got); check("R1 cap lo", got, 8'h00);
    bus_read(3'd3, got); check("R1 cap hi", got, 8'h00);
  endtask

  task automatic t_counter;
    bus_write(3'd5, 8'h12); bus_write(3'd4, 8'h34);
    bus_read(3'd4, got); check("R8 cnt lo after load", got, 8'h34);
    bus_read(3'd5, got); check("R8 cnt hi via latch", got, 8'h12);
    bus_read(3'd4, got); check("R2 increment", got, 8'h36);
    bus_write(3'd5, 8'hFF); bus_write(3'd4, 8'hFF);
    bus_read(3'd4, got); check("R2 pre-wrap lo", got, 8'hFF);
    bus_read(3'd4, got); check("R2 wrap lo", got, 8'h00);
    bus_read(3'd5, got); check("R2 wrap hi", got, 8'h00);
  endtask

  task automatic t_fall_capture;
    cap_pin = 1'b1;  // rising edge while falling is selected
    idle(5);
    bus_read(3'd1, got); check("R4 opposite edge flag", got, 8'h00);
    bus_read(3'd2, got); check("R4 opposite edge cap", got, 8'h00);
    bus_write(3'd5, 8'h40); bus_write(3'd4, 8'h00);
    cap_pin = 1'b0;
    idle(3);
    bus_read(3'd1, got); check("R3 flag set", got, 8'h01);
    bus_read(3'd2, got); check("R3 R5 cap lo", got, 8'h02);
    bus_read(3'd3, got); check("R3 R6 cap hi", got, 8'h40);
  endtask

  task automatic t_clear;
    bus_write(3'd1, 8'h00);
    bus_read(3'd1, got); check("R7 write zero keeps flag", got, 8'h01);
    bus_write(3'd1, 8'h01);
    bus_read(3'd1, got); check("R7 write one clears", got, 8'h00);
  endtask

  task automatic t_rise_consistent;
    bus_write(3'd0, 8'h01);
    bus_read(3'd0, got); check("R4 ctrl readback", got, 8'h01);
    bus_write(3'd5, 8'h77); bus_write(3'd4, 8'hF0);
    cap_pin = 1'b1;
    bus_read(3'd2, got); check("R5 lo before capture", got, 8'h02);
    idle(2);
    bus_read(3'd3, got); check("R6 hi from latch after capture", got, 8'h40);
    bus_read(3'd2, got); check("R4 rising cap lo", got, 8'hF2);
    bus_read(3'd3, got); check("R4 rising cap hi", got, 8'h77);
    bus_read(3'd1, got); check("R3 flag rising", got, 8'h01);
  endtask

  task automatic t_capture_beats_clear;
    bus_write(3'd0, 8'h00);
    bus_write(3'd1, 8'h01);
    bus_read(3'd1, got); check("R7 flag cleared first", got, 8'h00);
    cap_pin = 1'b0;
    idle(2);
    bus_write(3'd1, 8'h01);
    bus_read(3'd1, got); check("R7 capture wins over clear", got, 8'h01);
  endtask

  task automatic t_shared_latch;
    bus_write(3'd5, 8'h5A); bus_write(3'd4, 8'h00);
    bus_read(3'd2, got);
    bus_read(3'd4, got);
    bus_read(3'd3, got); check("R8 latch shared with counter", got, 8'h5A);
  endtask

  task automatic t_unmapped;
    bus_read(3'd6, got); check("R9 addr 6 zero", got, 8'h00);
    bus_read(3'd7, got); check("R9 addr 7 zero", got, 8'h00);
    idle(2);
    check("R9 rdata holds without read", bus_rdata, 8'h00);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_counter;
    t_fall_capture;
    t_clear;
    t_rise_consistent;
    t_capture_beats_clear;
    t_shared_latch;
    t_unmapped;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule